// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Direction Arbitration

The block controls eight general-purpose I/O pins through a small register file reached over a synchronous register port. Software sets an output value, a direction and a drive strength for each pin. It can also read back the state of the pads. Each pin produces an output-enable, an output value and a reduced-drive select for the pad cell, which sits outside the block.

Software direction is the default source of a pin's direction, but attached peripherals can take it over. A serial transmit channel forces its pin to drive. A serial receive channel forces its pin to listen. A shift-register (SPI) channel supplies its own direction bit. When a peripheral lets go of a pin, the software direction bit takes effect again with no further action.

Pad inputs pass through a two-flop synchronizer before anything reads them. A change at a pad therefore becomes visible on the read port two clock edges later.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, drive and output-value registers read 0, and pad_oe_o, pad_out_o and pad_lowdrv_o are all 0.
- R2: With no peripheral enabled on a pin, pad_oe_o for that pin equals its direction bit: 1 drives the pin, 0 leaves it as an input.
- R3: If neither serial enable is set on a pin and spi_en_i is set, pad_oe_o for that pin equals spi_oe_i.
- R4: If sci_tx_en_i is set on a pin, pad_oe_o is 1 for that pin, whatever the direction bit and the SPI signals are. This holds even when sci_rx_en_i is also set on the same pin.
- R5: If sci_rx_en_i is set and sci_tx_en_i is clear on a pin, pad_oe_o is 0 for that pin, whatever the direction bit and the SPI signals are.
- R6: When every peripheral enable on a pin is cleared, pad_oe_o returns to that pin's direction bit in the same cycle.
- R7: A read at address 3 returns the synchronized pad value for all pins, whatever their direction. A pad change shows there after exactly two rising clock edges and does not show after only one.
- R8: A write to address 3 has no effect on any register or output.
- R9: A read at address 0 returns, for each pin, the stored output value if pad_oe_o is 1 and the synchronized pad value if pad_oe_o is 0.
- R10: Address 2 holds the drive register. It can be read and written at any time, and pad_lowdrv_o mirrors it (1 selects reduced drive). pad_lowdrv_o changes only after a write to address 2.
- R11: A write to address 0 stores the output value whatever the pin directions are, and pad_out_o presents that value. Address 1 holds the direction register and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 output value, 1 direction, 2 drive, 3 pad input |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the register at addr_i, combinational |
| pad_i | input | 8 | Raw pad levels, asynchronous to clk_i |
| pad_oe_o | output | 8 | Per-pin output enable after arbitration |
| pad_out_o | output | 8 | Per-pin output value |
| pad_lowdrv_o | output | 8 | Per-pin reduced-drive select |
| spi_en_i | input | 8 | SPI channel owns the pin |
| spi_oe_i | input | 8 | Direction requested by the SPI channel |
| sci_tx_en_i | input | 8 | Serial transmit channel enabled on the pin |
| sci_rx_en_i | input | 8 | Serial receive channel enabled on the pin |

## Verification
The bench targets the arbitration corners. A pin with both serial enables set must drive: a design that gives receive priority would release it. A design that lets the direction bit leak through would fail to force pins while the direction register disagrees with a peripheral. A design that latches the override would not hand the pin back to software when the peripheral enables drop. The synchronizer latency is probed one edge early and on the exact edge, which catches a missing or an extra stage. Writes to the pad-input address are also checked to leave the other registers and the outputs unchanged.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_DRV  = 2'd2,
    ADDR_IN   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];
  logic         seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
      seen_q <= 1'b1;
    end
  end

  assign q_o = st_q[STAGES-1];

  // R7: first stage captures the pad sampled one edge earlier
  a_r7_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (st_q[0] == $past(d_i)));
endmodule

// File: rtl/gpio_dir_arb.sv
module gpio_dir_arb #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] spi_en_i,
  input  logic [W-1:0] spi_oe_i,
  input  logic [W-1:0] tx_en_i,
  input  logic [W-1:0] rx_en_i,
  output logic [W-1:0] oe_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (tx_en_i[p])       oe_o[p] = 1'b1;
      else if (rx_en_i[p])  oe_o[p] = 1'b0;
      else if (spi_en_i[p]) oe_o[p] = spi_oe_i[p];
      else                  oe_o[p] = dir_i[p];
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] pad_sync_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] drv_o
);
  logic [W-1:0] data_q, dir_q, drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_DATA: data_q <= wdata_i;
        ADDR_DIR:  dir_q  <= wdata_i;
        ADDR_DRV:  drv_q  <= wdata_i;
        default:   ; // input register is read-only
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = (data_q & oe_i) | (pad_sync_i & ~oe_i);
      ADDR_DIR:  rdata_o = dir_q;
      ADDR_DRV:  rdata_o = drv_q;
      default:   rdata_o = pad_sync_i;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign drv_o  = drv_q;

  a_r8_in_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_IN) |=> ($stable(data_q) && $stable(dir_q) && $stable(drv_q)));

  a_r10_drv_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_DRV) |=> $stable(drv_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_lowdrv_o,
  input  logic [N_PINS-1:0] spi_en_i,
  input  logic [N_PINS-1:0] spi_oe_i,
  input  logic [N_PINS-1:0] sci_tx_en_i,
  input  logic [N_PINS-1:0] sci_rx_en_i
);
  logic [N_PINS-1:0] pad_sync, dir, oe;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  gpio_dir_arb #(.W(N_PINS)) u_arb (
    .dir_i    (dir),
    .spi_en_i (spi_en_i),
    .spi_oe_i (spi_oe_i),
    .tx_en_i  (sci_tx_en_i),
    .rx_en_i  (sci_rx_en_i),
    .oe_o     (oe)
  );

  gpio_regs #(.W(N_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .oe_i       (oe),
    .pad_sync_i (pad_sync),
    .rdata_o    (rdata_o),
    .data_o     (pad_out_o),
    .dir_o      (dir),
    .drv_o      (pad_lowdrv_o)
  );

  assign pad_oe_o = oe;

  a_r2_dir_follows_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~(sci_tx_en_i | sci_rx_en_i | spi_en_i)) & (pad_oe_o ^ dir)) == '0);

  a_r3_spi_owns_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_en_i & ~sci_tx_en_i & ~sci_rx_en_i & (pad_oe_o ^ spi_oe_i)) == '0);

  a_r4_tx_forces_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_tx_en_i & ~pad_oe_o) == '0);

  a_r5_rx_forces_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_rx_en_i & ~sci_tx_en_i & pad_oe_o) == '0);
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pad = '0, oe, pout, lowdrv;
  logic [7:0] spi_en = '0, spi_oe = '0, tx_en = '0, rx_en = '0;

  int checks = 0, failures = 0;
  logic [7:0] m_data = '0, m_dir = '0, m_drv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .pad_oe_o(oe), .pad_out_o(pout),
    .pad_lowdrv_o(lowdrv), .spi_en_i(spi_en), .spi_oe_i(spi_oe),
    .sci_tx_en_i(tx_en), .sci_rx_en_i(rx_en)
  );

  function automatic logic [7:0] exp_oe(logic [7:0] d, logic [7:0] se, logic [7:0] so,
                                        logic [7:0] tx, logic [7:0] rx);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = tx[i] ? 1'b1 : rx[i] ? 1'b0 : se[i] ? so[i] : d[i];
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    case (a)
      2'd0: m_data = d;
      2'd1: m_dir  = d;
      2'd2: m_drv  = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check_all(string tag);
    logic [7:0] e, v;
    e = exp_oe(m_dir, spi_en, spi_oe, tx_en, rx_en);
    chk({tag, " R2/R3/R4/R5 oe"}, oe, e);
    chk({tag, " R11 pad_out"}, pout, m_data);
    chk({tag, " R10 lowdrv"}, lowdrv, m_drv);
    rd(2'd0, v); chk({tag, " R9 data read"}, v, (m_data & e) | (pad & ~e));
    rd(2'd1, v); chk({tag, " R11 dir read"}, v, m_dir);
    rd(2'd2, v); chk({tag, " R10 drv read"}, v, m_drv);
    rd(2'd3, v); chk({tag, " R7 input read"}, v, pad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", oe, 8'h00); chk("R1 pad_out", pout, 8'h00); chk("R1 lowdrv", lowdrv, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("reset");

    // R7 exact latency
    pad = 8'hA5; repeat (3) @(negedge clk);
    pad = 8'h3C; @(negedge clk);
    rd(2'd3, v); chk("R7 one edge", v, 8'hA5);
    @(negedge clk);
    rd(2'd3, v); chk("R7 two edges", v, 8'h3C);

    // R2 and R11
    wr(2'd1, 8'h0F); wr(2'd0, 8'h96); wr(2'd2, 8'h5A);
    repeat (2) @(negedge clk);
    check_all("R2 dir");

    // R4: TX + RX same pin -> out; R5 rx forces in
    tx_en = 8'h30; rx_en = 8'h33; #1;
    chk("R4 tx wins", oe, 8'h3C);
    // R3 spi
    tx_en = 0; rx_en = 0; spi_en = 8'hF0; spi_oe = 8'hA0; #1;
    chk("R3 spi dir", oe, 8'hAF);
    // R6 reversion
    spi_en = 0; #1;
    chk("R6 revert", oe, 8'h0F);

    // R8 write to input address ignored
    wr(2'd3, 8'hFF);
    check_all("R8");

    // R10 lowdrv only on write
    wr(2'd0, 8'h11); wr(2'd1, 8'hEE);
    chk("R10 stable", lowdrv, 8'h5A);

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [1:0] a;
      a = 2'($urandom);
      if ($urandom % 4 != 0) wr(a, 8'($urandom));
      @(negedge clk);
      pad = 8'($urandom);
      spi_en = 8'($urandom); spi_oe = 8'($urandom);
      tx_en = 8'($urandom) & 8'($urandom); rx_en = 8'($urandom) & 8'($urandom);
      repeat (2) @(negedge clk);
      check_all("rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule